// File: doc/BRIEF.md
# Peripheral Access Protection Checker

This block sits between an upstream bus and a group of peripheral slaves. Every peripheral has its own two attribute bits: one says the peripheral is Secure, the other says it is privileged. The upstream bus delivers one transaction per cycle. Each transaction carries a peripheral index, decoded elsewhere, and three attributes: secure, privileged and instruction fetch. The checker compares these attributes with the settings of the target peripheral. A transaction that passes is forwarded to the slave side one cycle later. A transaction that fails is answered locally: a read returns zero, a write is dropped, and nothing reaches the slave.

A failed check raises one or more of three sticky fault flags: privilege, security and fetch. It also records the index of the offending peripheral. After that, the flag register and the recorded index are frozen until software has cleared every flag. Clearing uses write-one-to-clear. Two interrupt lines are formed from the flags through enable bits. The security flag feeds the secure line. The privilege and fetch flags feed the privileged line.

The configuration, flag, clear, enable and fault-index registers are reached through a simple register port. A write takes effect at the clock edge where it is sampled. Read data is registered.

Top module: `periph_guard`

## Requirements
- R1: After reset, every Secure bit and every privileged bit reads 1, the flag, enable and fault-index registers read 0, and both interrupt outputs are 0.
- R2: A privilege fault (flag bit 0) is raised exactly when a transaction with txn_priv=0 targets a peripheral whose privileged bit is 1. Every other privilege combination passes this check.
- R3: A security fault (flag bit 1) is raised whenever txn_secure differs from the target's Secure bit. This holds in both directions.
- R4: A fetch fault (flag bit 2) is raised for every transaction with txn_fetch=1, whatever the other attributes are.
- R5: The response comes one cycle after txn_valid is sampled. A passing transaction gives fwd_valid=1 with the same write flag, index and write data. A failing one gives deny_valid=1, deny_rdata=0 and fwd_valid=0, so a denied write reaches no slave. The two outputs are never high together.
- R6: When several fault conditions hit on one transaction, all of their flags are set at the same edge and that transaction's index is recorded once.
- R7: Faults are captured only while all flags are 0. While any flag is 1, new faults change neither the flags nor the recorded index. Writing 1s to the clear register clears the matching flags, and writing 0s has no effect.
- R8: irq_secure follows (flag bit 1 AND enable bit 1) one cycle after the flags. irq_priv follows ((flag bit 0 AND enable bit 0) OR (flag bit 2 AND enable bit 2)) one cycle after the flags.
- R9: Register map with default parameters: 0 holds Secure bits for peripherals 0–31 and 1 holds them for 32–63. 2 and 3 hold the privileged bits in the same split. 4 is the flags (read-only). 5 is clear (write-one-to-clear, reads 0). 6 is the interrupt enables, in the same bit positions as the flags. 7 is the fault index in bits 5:0. Peripheral n uses bit n mod 32 of bank n/32. cfg_rdata is valid one cycle after cfg_re.
- R10: A clear write and a fault in the same cycle while a flag is set: only the clear is applied. The fault is not captured, even if the clear empties the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_idx | input | IDX_W | Target peripheral index |
| txn_wdata | input | DATA_W | Write data |
| txn_secure | input | 1 | Transaction is Secure |
| txn_priv | input | 1 | Transaction is privileged |
| txn_fetch | input | 1 | Transaction is an instruction fetch |
| fwd_valid | output | 1 | Passed transaction toward the slave |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_idx | output | IDX_W | Forwarded peripheral index |
| fwd_wdata | output | DATA_W | Forwarded write data |
| deny_valid | output | 1 | Local response to a blocked transaction |
| deny_rdata | output | DATA_W | Read data of the local response (zero) |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Registered read data |
| irq_secure | output | 1 | Secure interrupt line |
| irq_priv | output | 1 | Privileged interrupt line |

## Verification
Two events can fall on the same clock edge: a write-one-to-clear and the capture of a new fault. The bench forces this collision directly. It first raises a flag, then drives a clear of every bit together with a faulting transaction. It then checks that the flags read back as zero and that the recorded index is still the earlier one. A second transaction that faults afterwards must be captured. The random phase keeps clears, configuration writes and faulting transactions interleaved, so captures against frozen flags happen often. It compares the flags, the index and both interrupt lines with a reference model after every step.

// File: rtl/periph_guard_pkg.sv
package periph_guard_pkg;

  localparam int NFLT    = 3;
  localparam int FB_PRIV = 0;
  localparam int FB_SEC  = 1;
  localparam int FB_INST = 2;

  // bit 2 = fetch, bit 1 = security, bit 0 = privilege
  typedef struct packed {
    logic inst;
    logic sec;
    logic priv;
  } fault_t;

endpackage

// File: rtl/pg_attr_bank.sv
module pg_attr_bank #(
  parameter int NB     = 2,
  parameter int BW     = 32,
  parameter int IDX_W  = 6,
  parameter int BSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BSEL_W-1:0] wr_bank,
  input  logic [BW-1:0]     wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit,
  output logic [NB*BW-1:0]  flat
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '1;
      else if (wr_en && (wr_bank == BSEL_W'(b)))
        word_q <= wr_data;
    end
    assign flat[b*BW +: BW] = word_q;
  end

  assign rd_bit = flat[rd_idx];

endmodule

// File: rtl/pg_fault_eval.sv
module pg_fault_eval
  import periph_guard_pkg::*;
(
  input  logic   req_secure,
  input  logic   req_priv,
  input  logic   req_fetch,
  input  logic   tgt_secure,
  input  logic   tgt_priv,
  output fault_t hit
);

  always_comb begin
    hit.priv = tgt_priv & ~req_priv;
    hit.sec  = tgt_secure ^ req_secure;
    hit.inst = req_fetch;
  end

endmodule

// File: rtl/pg_fault_log.sv
module pg_fault_log
  import periph_guard_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  fault_t           hit,
  input  logic [IDX_W-1:0] evt_idx,
  input  logic             clr_en,
  input  logic [NFLT-1:0]  clr_mask,
  input  logic             en_we,
  input  logic [NFLT-1:0]  en_wdata,
  output fault_t           flags_q,
  output logic [IDX_W-1:0] id_q,
  output logic [NFLT-1:0]  en_q,
  output logic             irq_sec,
  output logic             irq_prv
);

  logic idle;
  assign idle = (flags_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      id_q    <= '0;
    end else if (idle) begin
      if (evt && (hit != '0)) begin
        flags_q <= hit;
        id_q    <= evt_idx;
      end
    end else if (clr_en) begin
      flags_q <= flags_q & ~fault_t'(clr_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (en_we)
      en_q <= en_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_sec <= 1'b0;
      irq_prv <= 1'b0;
    end else begin
      irq_sec <= flags_q.sec & en_q[FB_SEC];
      irq_prv <= (flags_q.priv & en_q[FB_PRIV]) | (flags_q.inst & en_q[FB_INST]);
    end
  end

endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import periph_guard_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int BANK_W = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_valid,
  input  logic              txn_write,
  input  logic [IDX_W-1:0]  txn_idx,
  input  logic [DATA_W-1:0] txn_wdata,
  input  logic              txn_secure,
  input  logic              txn_priv,
  input  logic              txn_fetch,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [IDX_W-1:0]  fwd_idx,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              deny_valid,
  output logic [DATA_W-1:0] deny_rdata,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq_secure,
  output logic              irq_priv
);

  localparam int NPERIPH = 2 ** IDX_W;
  localparam int NB      = NPERIPH / BANK_W;
  localparam int BSEL_W  = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [ADDR_W-1:0] A_PRIV0 = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(2 * NB);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(2 * NB + 1);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(2 * NB + 2);
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(2 * NB + 3);

  logic                sec_we, priv_we;
  logic [BSEL_W-1:0]   sec_bank, priv_bank;
  logic                tgt_secure, tgt_priv;
  logic [NB*BANK_W-1:0] sec_flat, priv_flat;
  fault_t              txn_hit;
  fault_t              flags_q;
  logic [IDX_W-1:0]    fault_id_q;
  logic [NFLT-1:0]     irq_en_q;
  logic                clr_req, en_req;
  logic [ADDR_W-1:0]   priv_off;

  // register decode
  assign sec_we    = cfg_we && (cfg_addr < A_PRIV0);
  assign priv_we   = cfg_we && (cfg_addr >= A_PRIV0) && (cfg_addr < A_FLAGS);
  assign priv_off  = cfg_addr - A_PRIV0;
  assign sec_bank  = BSEL_W'(cfg_addr);
  assign priv_bank = BSEL_W'(priv_off);
  assign clr_req   = cfg_we && (cfg_addr == A_CLR);
  assign en_req    = cfg_we && (cfg_addr == A_EN);

  pg_attr_bank #(.NB(NB), .BW(BANK_W), .IDX_W(IDX_W), .BSEL_W(BSEL_W)) u_sec (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (sec_we),
    .wr_bank (sec_bank),
    .wr_data (cfg_wdata[BANK_W-1:0]),
    .rd_idx  (txn_idx),
    .rd_bit  (tgt_secure),
    .flat    (sec_flat)
  );

  pg_attr_bank #(.NB(NB), .BW(BANK_W), .IDX_W(IDX_W), .BSEL_W(BSEL_W)) u_priv (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (priv_we),
    .wr_bank (priv_bank),
    .wr_data (cfg_wdata[BANK_W-1:0]),
    .rd_idx  (txn_idx),
    .rd_bit  (tgt_priv),
    .flat    (priv_flat)
  );

  pg_fault_eval u_eval (
    .req_secure (txn_secure),
    .req_priv   (txn_priv),
    .req_fetch  (txn_fetch),
    .tgt_secure (tgt_secure),
    .tgt_priv   (tgt_priv),
    .hit        (txn_hit)
  );

  pg_fault_log #(.IDX_W(IDX_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .evt      (txn_valid),
    .hit      (txn_hit),
    .evt_idx  (txn_idx),
    .clr_en   (clr_req),
    .clr_mask (cfg_wdata[NFLT-1:0]),
    .en_we    (en_req),
    .en_wdata (cfg_wdata[NFLT-1:0]),
    .flags_q  (flags_q),
    .id_q     (fault_id_q),
    .en_q     (irq_en_q),
    .irq_sec  (irq_secure),
    .irq_prv  (irq_priv)
  );

  // forward or answer locally
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid  <= 1'b0;
      fwd_write  <= 1'b0;
      fwd_idx    <= '0;
      fwd_wdata  <= '0;
      deny_valid <= 1'b0;
      deny_rdata <= '0;
    end else begin
      fwd_valid  <= txn_valid && (txn_hit == '0);
      deny_valid <= txn_valid && (txn_hit != '0);
      deny_rdata <= '0;
      if (txn_valid && (txn_hit == '0)) begin
        fwd_write <= txn_write;
        fwd_idx   <= txn_idx;
        fwd_wdata <= txn_wdata;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_re) begin
      if (cfg_addr < A_PRIV0)
        cfg_rdata <= DATA_W'(sec_flat[int'(cfg_addr)*BANK_W +: BANK_W]);
      else if (cfg_addr < A_FLAGS)
        cfg_rdata <= DATA_W'(priv_flat[int'(priv_off)*BANK_W +: BANK_W]);
      else if (cfg_addr == A_FLAGS)
        cfg_rdata <= DATA_W'(flags_q);
      else if (cfg_addr == A_EN)
        cfg_rdata <= DATA_W'(irq_en_q);
      else if (cfg_addr == A_ID)
        cfg_rdata <= DATA_W'(fault_id_q);
      else
        cfg_rdata <= '0;
    end
  end

endmodule

// File: rtl/periph_guard_chk.sv
module periph_guard_chk
  import periph_guard_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             txn_valid,
  input logic             txn_fetch,
  input logic             fwd_valid,
  input logic             deny_valid,
  input logic [NFLT-1:0]  flags_q,
  input logic [IDX_W-1:0] fault_id_q,
  input logic             clr_req,
  input logic [NFLT-1:0]  irq_en_q,
  input logic             irq_secure,
  input logic             irq_priv
);

  // R5: never both responses at once
  p_one_resp_r5: assert property (@(posedge clk) disable iff (rst)
    !(fwd_valid && deny_valid));

  // R5: each transaction gets exactly one response next cycle
  p_resp_follows_r5: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> (fwd_valid || deny_valid));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> !(fwd_valid || deny_valid));

  // R4: fetches are always blocked
  p_fetch_denied_r4: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_fetch) |=> (deny_valid && !fwd_valid));

  // R7: frozen while any flag is set and no clear arrives
  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    ((flags_q != '0) && !clr_req) |=> ($stable(flags_q) && $stable(fault_id_q)));

  // R7: index never moves while flags are non-zero
  p_id_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (flags_q != '0) |=> $stable(fault_id_q));

  // R8: interrupt line mapping
  p_irq_sec_on_r8: assert property (@(posedge clk) disable iff (rst)
    (flags_q[FB_SEC] && irq_en_q[FB_SEC]) |=> irq_secure);

  p_irq_sec_off_r8: assert property (@(posedge clk) disable iff (rst)
    !(flags_q[FB_SEC] && irq_en_q[FB_SEC]) |=> !irq_secure);

  p_irq_prv_on_r8: assert property (@(posedge clk) disable iff (rst)
    ((flags_q[FB_PRIV] && irq_en_q[FB_PRIV]) || (flags_q[FB_INST] && irq_en_q[FB_INST]))
      |=> irq_priv);

  p_irq_prv_off_r8: assert property (@(posedge clk) disable iff (rst)
    !((flags_q[FB_PRIV] && irq_en_q[FB_PRIV]) || (flags_q[FB_INST] && irq_en_q[FB_INST]))
      |=> !irq_priv);

endmodule

bind periph_guard periph_guard_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .txn_valid  (txn_valid),
  .txn_fetch  (txn_fetch),
  .fwd_valid  (fwd_valid),
  .deny_valid (deny_valid),
  .flags_q    (flags_q),
  .fault_id_q (fault_id_q),
  .clr_req    (clr_req),
  .irq_en_q   (irq_en_q),
  .irq_secure (irq_secure),
  .irq_priv   (irq_priv)
);

// File: tb/periph_guard_bench.sv
`timescale 1ns/1ps
module periph_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txn_valid = 0, txn_write = 0, txn_secure = 0, txn_priv = 0, txn_fetch = 0;
  logic [5:0]  txn_idx = '0;
  logic [31:0] txn_wdata = '0;
  logic        fwd_valid, fwd_write, deny_valid;
  logic [5:0]  fwd_idx;
  logic [31:0] fwd_wdata, deny_rdata;
  logic        cfg_we = 0, cfg_re = 0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_secure, irq_priv;

  always #4 clk = ~clk;

  periph_guard u_periph_guard (.*);

  // reference model
  logic [63:0] sec_m = '1, priv_m = '1;
  logic [2:0]  flags_m = '0, en_m = '0;
  logic [5:0]  id_m = '0;
  int n_chk = 0, n_fail = 0;

  function automatic logic [2:0] calc(input logic [5:0] i, input logic s, input logic p, input logic f);
    return {f, s ^ sec_m[i], priv_m[i] & ~p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd0: sec_m[31:0]   = d;
      4'd1: sec_m[63:32]  = d;
      4'd2: priv_m[31:0]  = d;
      4'd3: priv_m[63:32] = d;
      4'd5: if (flags_m != 0) flags_m = flags_m & ~d[2:0];
      4'd6: en_m = d[2:0];
      default: ;
    endcase
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    model_wr(a, d);
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    cfg_re = 1; cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
    cfg_re = 0;
  endtask

  task automatic do_txn(input logic [5:0] i, input logic w, input logic s, input logic p,
                        input logic f, input logic [31:0] d);
    logic [2:0] e;
    e = calc(i, s, p, f);
    txn_valid = 1; txn_idx = i; txn_write = w; txn_secure = s; txn_priv = p;
    txn_fetch = f; txn_wdata = d;
    @(negedge clk);
    txn_valid = 0;
    if (e != 0) begin
      chk("R5 deny_valid", {31'b0, deny_valid}, 32'd1);
      chk("R5 fwd_valid blocked", {31'b0, fwd_valid}, 32'd0);
      chk("R5 deny_rdata zero", deny_rdata, 32'd0);
      if (flags_m == 0) begin flags_m = e; id_m = i; end
    end else begin
      chk("R5 fwd_valid", {31'b0, fwd_valid}, 32'd1);
      chk("R5 deny idle", {31'b0, deny_valid}, 32'd0);
      chk("R5 fwd fields", {fwd_wdata[23:0], fwd_write, 1'b0, fwd_idx},
          {d[23:0], w, 1'b0, i});
    end
  endtask

  task automatic chk_state(input string tag);
    logic [31:0] r;
    reg_rd(4'd4, r);
    chk({tag, " flags"}, r, {29'b0, flags_m});
    reg_rd(4'd7, r);
    chk({tag, " fault id"}, r, {26'b0, id_m});
    chk("R8 irq_secure", {31'b0, irq_secure}, {31'b0, flags_m[1] & en_m[1]});
    chk("R8 irq_priv", {31'b0, irq_priv},
        {31'b0, (flags_m[0] & en_m[0]) | (flags_m[2] & en_m[2])});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 / R9 reset values
    for (int a = 0; a < 8; a++) begin
      reg_rd(4'(a), r);
      chk((a < 4) ? "R1 attr reset" : "R1 ctrl reset", r, (a < 4) ? 32'hFFFF_FFFF : 32'd0);
    end
    chk("R1 irq_secure reset", {31'b0, irq_secure}, 32'd0);
    chk("R1 irq_priv reset", {31'b0, irq_priv}, 32'd0);

    // R5 / R2 passing access with default config
    do_txn(6'd5, 1'b1, 1'b1, 1'b1, 1'b0, 32'hA5A5_1234);
    chk_state("R2 no fault");

    // R6 all three faults at once
    reg_wr(4'd6, 32'd7);
    do_txn(6'd5, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0);
    chk_state("R6 triple");
    chk("R6 flags all", {29'b0, flags_m}, 32'd7);

    // R7 frozen against new faults, partial clear
    do_txn(6'd9, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
    chk_state("R7 frozen");
    reg_wr(4'd5, 32'd0);
    chk_state("R7 zero clear");
    reg_wr(4'd5, 32'd1);
    do_txn(6'd9, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
    chk_state("R7 partial");
    reg_wr(4'd5, 32'd6);
    chk_state("R7 cleared");

    // R10 clear and fault in the same cycle
    do_txn(6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    chk_state("R10 setup");
    cfg_we = 1; cfg_addr = 4'd5; cfg_wdata = 32'd7;
    txn_valid = 1; txn_idx = 6'd7; txn_secure = 0; txn_priv = 1; txn_fetch = 0;
    @(negedge clk);
    cfg_we = 0; txn_valid = 0;
    flags_m = 3'd0;
    chk("R10 blocked during clear", {31'b0, deny_valid}, 32'd1);
    chk_state("R10 clear wins");
    chk("R10 id kept", {26'b0, id_m}, 32'd3);
    do_txn(6'd7, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
    chk_state("R10 recapture");
    reg_wr(4'd5, 32'd7);

    // R3 both directions, R9 bank bit mapping
    reg_wr(4'd1, 32'h0000_0004);        // only peripheral 34 Secure in bank 1
    do_txn(6'd40, 1'b1, 1'b1, 1'b1, 1'b0, 32'h11);
    chk_state("R3 secure to NS");
    reg_wr(4'd5, 32'd7);
    do_txn(6'd40, 1'b1, 1'b0, 1'b1, 1'b0, 32'h22);
    do_txn(6'd34, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    chk_state("R3 NS to secure");
    reg_wr(4'd5, 32'd7);

    // R2 unprivileged to unprivileged peripheral
    reg_wr(4'd3, 32'h0000_0100);        // only peripheral 40 privileged in bank 1
    do_txn(6'd41, 1'b0, 1'b0, 1'b0, 1'b0, 32'h33);
    do_txn(6'd40, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    chk_state("R2 unpriv to priv");
    reg_rd(4'd3, r);
    chk("R9 priv bank1 readback", r, 32'h0000_0100);
    reg_rd(4'd5, r);
    chk("R9 clear reads zero", r, 32'd0);
    reg_wr(4'd5, 32'd7);

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [5:0] i;
      logic s;
      if ($urandom % 4 == 0) reg_wr(4'($urandom % 4), $urandom);
      if ($urandom % 6 == 0) reg_wr(4'd6, $urandom % 8);
      i = 6'($urandom);
      s = ($urandom % 4 == 0) ? ~sec_m[i] : sec_m[i];
      do_txn(i, 1'($urandom), s, 1'($urandom), ($urandom % 8 == 0), $urandom);
      chk_state("R7 random");
      if ($urandom % 2 == 0) reg_wr(4'd5, $urandom % 8);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule